// File: doc/BRIEF.md
# Ethernet PHY Status LED Driver

This block turns the status of a 10/100 Ethernet PHY into four LED outputs: activity, link, 100 Mb/s speed and full duplex. Carrier sense, the two link-test results (one for 10 Mb/s, one for 100 Mb/s), the resolved speed, the duplex mode, an auto-negotiation-busy flag and a line-isolate control bit come in as plain inputs. Each input passes through a two-flop synchronizer before it is used.

A short burst of carrier sense is easy to miss on an LED. The activity indication therefore stays on for a fixed hold time after carrier sense drops. The hold length is given in milliseconds and turned into a cycle count from the clock-frequency parameter. Board straps sampled during reset choose, for each LED, whether it is driven active-high or active-low. This lets one design suit either LED wiring.

All logic decides in active-high terms. The polarity of each LED is applied only in a final XOR stage.

Top module: `phy_led_ctrl`

## Requirements
- R1: While `rst_n` is low, `strap_pol` is sampled on every clock edge. The value present at the last edge before `rst_n` rises is kept until the next reset, and later changes on `strap_pol` have no effect. Strap bit 0 belongs to the activity LED, bit 1 to link, bit 2 to speed and bit 3 to duplex. A strap bit of 1 makes its LED active-low; a 0 makes it active-high.
- R2: While `rst_n` is low, every LED output sits at its inactive level, which equals its strap bit as currently presented on `strap_pol`.
- R3: Every status input passes through two flip-flops, so a change shows at the LEDs after the second rising clock edge. The activity LED is active while synchronized carrier sense is high.
- R4: After synchronized carrier sense falls, the activity LED stays active for exactly HOLD_CYCLES = (CLK_FREQ_HZ/1000)*HOLD_MS further clock cycles. Any cycle with synchronized carrier sense high restarts the full hold.
- R5: The link LED follows `link_ok_100` when `speed_100` is 1 and `link_ok_10` when it is 0.
- R6: The speed LED is active when `speed_100` or `aneg_busy` is 1. It is inactive when both are 0, and it is always inactive while `isolate` is 1.
- R7: The duplex LED is active only when `full_duplex` is 1 and the link LED's condition (R5) is true.
- R8: Each output equals its logical (active-high) value XOR its latched strap bit, so the same logical state gives inverted pin levels under opposite straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap_pol | input | 4 | Polarity straps: bit 0 activity, bit 1 link, bit 2 speed, bit 3 duplex |
| crs | input | 1 | Carrier sense |
| link_ok_10 | input | 1 | 10 Mb/s link test passed |
| link_ok_100 | input | 1 | 100 Mb/s link test passed |
| speed_100 | input | 1 | Resolved speed: 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | Link runs in full duplex |
| aneg_busy | input | 1 | Auto-negotiation in progress |
| isolate | input | 1 | Line-isolate control bit |
| led_act | output | 1 | Activity LED pin level |
| led_link | output | 1 | Link LED pin level |
| led_spd | output | 1 | Speed LED pin level |
| led_fdx | output | 1 | Duplex LED pin level |

## Verification
The reset-time check reads the polarity from `strap_pol` as it stands in the same cycle. It therefore assumes the strap pins are steady at the sampling edge, and the stimulus changes them only at falling edges. The checks made after reset assume the two-flop synchronizers have settled, and they relate the LEDs to the synchronized carrier-sense and isolate bits rather than to the raw pins. The stimulus changes each input at most once per falling edge and holds every pattern for at least two rising edges. Retrigger and hold tests use a scaled-down clock frequency, so that the hold spans 128 cycles.

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl #(
  parameter int unsigned CLK_FREQ_HZ = 25_000_000,
  parameter int unsigned HOLD_MS     = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] strap_pol,
  input  logic       crs,
  input  logic       link_ok_10,
  input  logic       link_ok_100,
  input  logic       speed_100,
  input  logic       full_duplex,
  input  logic       aneg_busy,
  input  logic       isolate,
  output logic       led_act,
  output logic       led_link,
  output logic       led_spd,
  output logic       led_fdx
);

  localparam int unsigned HOLD_CYCLES = (CLK_FREQ_HZ / 1000) * HOLD_MS;
  localparam int unsigned CNT_W       = $clog2(HOLD_CYCLES + 1);
  localparam int unsigned NIN         = 7;

  logic [NIN-1:0]   meta_q, sync_q;
  logic [3:0]       pol_q;
  logic [CNT_W-1:0] hold_cnt;

  logic crs_s, l10_s, l100_s, spd_s, fdx_s, aneg_s, iso_s;
  logic hold_busy;
  logic [3:0] logical, pol_eff;

  assign {iso_s, aneg_s, fdx_s, spd_s, l100_s, l10_s, crs_s} = sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_q   <= '0;
      hold_cnt <= '0;
      pol_q    <= strap_pol;
    end else begin
      meta_q <= {isolate, aneg_busy, full_duplex, speed_100,
                 link_ok_100, link_ok_10, crs};
      sync_q <= meta_q;
      if (crs_s)
        hold_cnt <= CNT_W'(HOLD_CYCLES);
      else if (hold_busy)
        hold_cnt <= hold_cnt - CNT_W'(1);
    end
  end

  assign hold_busy = (hold_cnt != '0);

  logic link_on;
  assign link_on = spd_s ? l100_s : l10_s;

  assign logical[0] = crs_s | hold_busy;
  assign logical[1] = link_on;
  assign logical[2] = ~iso_s & (spd_s | aneg_s);
  assign logical[3] = fdx_s & link_on;

  assign pol_eff = rst_n ? pol_q : strap_pol;

  logic [3:0] pins;
  assign pins = (rst_n ? logical : 4'b0000) ^ pol_eff;

  assign {led_fdx, led_spd, led_link, led_act} = pins;

endmodule

module phy_led_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] strap_pol,
  input logic [3:0] pol,
  input logic [3:0] leds,
  input logic       crs_s,
  input logic       iso_s
);

  logic [3:0] on;
  assign on = leds ^ pol;

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r2_reset_inactive: assert (leds == strap_pol)
        else $error("R2 LEDs not inactive in reset");
    end
  end

  a_r1_pol_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(pol));

  a_r3_act_on_crs: assert property (@(posedge clk) disable iff (!rst_n)
    crs_s |-> on[0]);

  a_r4_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crs_s) |-> on[0]);

  a_r6_isolate_off: assert property (@(posedge clk) disable iff (!rst_n)
    iso_s |-> !on[2]);

  a_r7_fdx_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
    on[3] |-> on[1]);

endmodule

bind phy_led_ctrl phy_led_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .strap_pol (strap_pol),
  .pol       (pol_q),
  .leds      ({led_fdx, led_spd, led_link, led_act}),
  .crs_s     (crs_s),
  .iso_s     (iso_s)
);

// File: tb/phy_led_ctrl_tb.sv
`timescale 1ns/1ps
module phy_led_ctrl_tb;

  localparam int unsigned FREQ = 1000;
  localparam int unsigned HOLD = (FREQ / 1000) * 128;

  logic clk = 0;
  logic rst_n = 0;
  logic [3:0] strap_pol = 4'b0000;
  logic crs = 0, link_ok_10 = 0, link_ok_100 = 0, speed_100 = 0;
  logic full_duplex = 0, aneg_busy = 0, isolate = 0;
  logic led_act, led_link, led_spd, led_fdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  phy_led_ctrl #(.CLK_FREQ_HZ(FREQ)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_pol(strap_pol), .crs(crs),
    .link_ok_10(link_ok_10), .link_ok_100(link_ok_100), .speed_100(speed_100),
    .full_duplex(full_duplex), .aneg_busy(aneg_busy), .isolate(isolate),
    .led_act(led_act), .led_link(led_link), .led_spd(led_spd), .led_fdx(led_fdx)
  );

  // {isolate, aneg_busy, full_duplex, speed_100, link_ok_100, link_ok_10, exp {fdx,spd,link,act}}
  localparam logic [9:0] VEC [9] = '{
    10'b000000_0000,
    10'b000001_0010,
    10'b000101_0100,
    10'b001110_1110,
    10'b010000_0100,
    10'b110111_0010,
    10'b001011_1010,
    10'b001010_0000,
    10'b101110_1010
  };

  function automatic logic [3:0] leds();
    return {led_fdx, led_spd, led_link, led_act};
  endfunction

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] s);
    @(negedge clk);
    rst_n = 0;
    strap_pol = s;
    {crs, link_ok_10, link_ok_100, speed_100, full_duplex, aneg_busy, isolate} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_table(input logic [3:0] s);
    do_reset(s);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      {isolate, aneg_busy, full_duplex, speed_100, link_ok_100, link_ok_10} = VEC[i][9:4];
      repeat (2) @(negedge clk);
      check($sformatf("R5/R6/R7/R8 row %0d strap %b", i, s), leds(), VEC[i][3:0] ^ s);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    strap_pol = 4'b1010;
    repeat (2) @(negedge clk);
    check("R2 inactive in reset strap 1010", leds(), 4'b1010);
    strap_pol = 4'b0110;
    @(negedge clk);
    check("R2 inactive follows strap in reset", leds(), 4'b0110);
    rst_n = 1;
    @(negedge clk);
    strap_pol = 4'b1001;
    repeat (3) @(negedge clk);
    check("R1 strap ignored after reset", leds(), 4'b0110);

    // activity: bit0 active-high under strap 0110
    crs = 1;
    @(negedge clk);
    check("R3 not yet after one edge", leds(), 4'b0110);
    @(negedge clk);
    check("R3 activity on after two edges", leds(), 4'b0111);
    repeat (5) @(negedge clk);
    crs = 0;
    repeat (HOLD / 2) @(negedge clk);
    check("R4 held mid-window", leds(), 4'b0111);
    repeat (HOLD + 1 - HOLD / 2) @(negedge clk);
    check("R4 held last cycle", leds(), 4'b0111);
    @(negedge clk);
    check("R4 released after hold", leds(), 4'b0110);

    // retrigger with a one-cycle pulse during a hold
    crs = 1;
    repeat (3) @(negedge clk);
    crs = 0;
    repeat (HOLD / 2) @(negedge clk);
    crs = 1;
    @(negedge clk);
    crs = 0;
    repeat (HOLD + 1) @(negedge clk);
    check("R4 retriggered hold still on", leds(), 4'b0111);
    @(negedge clk);
    check("R4 retriggered hold ends", leds(), 4'b0110);

    // reset in the middle of a hold
    crs = 1;
    repeat (3) @(negedge clk);
    crs = 0;
    repeat (4) @(negedge clk);
    rst_n = 0;
    strap_pol = 4'b0011;
    @(negedge clk);
    check("R2 reset during hold forces inactive", leds(), 4'b0011);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R4 hold cleared by reset", leds(), 4'b0011);

    // active-low activity
    do_reset(4'b1111);
    crs = 1;
    repeat (2) @(negedge clk);
    check("R8 active-low activity", leds(), 4'b1110);
    crs = 0;

    run_table(4'b0000);
    run_table(4'b1111);

    // isolate wins over auto-negotiation and speed
    do_reset(4'b0000);
    {speed_100, aneg_busy, isolate} = 3'b111;
    repeat (2) @(negedge clk);
    check("R6 isolate forces speed off", leds() & 4'b0100, 4'b0000);
    isolate = 0;
    repeat (2) @(negedge clk);
    check("R6 speed on after isolate clears", leds() & 4'b0100, 4'b0100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule